// File: doc/BRIEF.md
# Set-Associative TLB Lookup Unit

This unit translates a 32-bit virtual address with 8 KB pages through a four-way, sixteen-set translation buffer. A request picks a set from the address and reads every way of that set through a combinational read port. It compares each stored page tag against the requested page number and then checks the matching entry. The checks are valid, process identity and write permission, and a valid check or a write check runs only when its enable input is set.

One cycle after a request the unit returns either a physical address or a single exception vector. When a lookup fails, it captures a cause word that refill software reads. When the entry is missing or invalid, it also loads a select word that names the slot the refill handler should write. The entry storage, segment translation and the refill handler are outside this block.

Top module: `tlb_lookup`

## Requirements
- R1: A request with `req_valid` high indexes set `req_addr[16:13]` and compares `req_addr[31:13]` against the tag of each way. On a hit, `rsp_paddr` equals the matching way's frame number in bits 31:13 and `req_addr[12:0]` in bits 12:0.
- R2: When several ways at the set hold the requested tag, the way with the lowest number supplies the frame.
- R3: `rsp_valid` is high for exactly the one cycle after each request cycle and low otherwise. The response fields hold their values until the next request.
- R4: When no way matches, the vector is 0x8, `rsp_hit` is 0 and `sel_reg` becomes the set index in bits 3:0 with zero in bits 5:4.
- R5: When `cfg_chk_valid` is 1 and the matching entry's valid flag is 0, the lookup fails with vector 0x8 and `sel_reg` is loaded as in R4. With `cfg_chk_valid` at 0, the valid flag does not affect the result.
- R6: An entry that is not global, whose PID is not 0xFF and whose PID differs from `cur_pid`, fails with vector 0xA. In that case `sel_reg` keeps its value.
- R7: A write (`req_write`=1) to an entry whose writable flag is 0 fails with vector 0xB when `cfg_chk_write` is 1. Reads, and writes with `cfg_chk_write` at 0, are not affected by the writable flag.
- R8: Only one vector is reported per lookup. The priority is miss or invalid first, then PID mismatch, then write protection.
- R9: On any failure, `cause_reg` becomes the following word: page number in bits 31:13, zero in bits 12:10, an access code in bits 9:8 (01 for a read, 10 for a write) and `cur_pid` in bits 7:0. A hit leaves `cause_reg` unchanged.
- R10: After reset, `rsp_valid`, `rsp_hit`, `rsp_vec`, `rsp_paddr`, `cause_reg` and `sel_reg` are all zero.
- R11: A hit reports `rsp_hit`=1 and `rsp_vec`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| cur_pid | input | 8 | Current process identifier |
| cfg_chk_valid | input | 1 | Enables the entry-valid check |
| cfg_chk_write | input | 1 | Enables the write-permission check |
| rd_index | output | 4 | Set index driven to the entry storage |
| rd_tag | input | 76 | Stored page tags, way w in bits 19w+18:19w |
| rd_pid | input | 32 | Stored PIDs, way w in bits 8w+7:8w |
| rd_pfn | input | 76 | Stored frame numbers, way w in bits 19w+18:19w |
| rd_global | input | 4 | Global flag per way |
| rd_valid | input | 4 | Valid flag per way |
| rd_writable | input | 4 | Writable flag per way |
| rsp_valid | output | 1 | Result strobe, one cycle after a request |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_vec | output | 4 | Exception vector, 0 on a hit |
| rsp_paddr | output | 32 | Physical address on a hit, 0 on a failure |
| cause_reg | output | 32 | Fault cause word |
| sel_reg | output | 6 | Refill slot: set index and way |

## Verification
The bench sweeps every way of every set on hits and every set on misses. It then runs every combination of global flag, valid flag, writable flag, three kinds of entry PID, access direction and both check enables on a single entry. This catches a design that reverses the fault priority, for example one that reports 0xB for an invalid entry, and a design that ignores an enable or treats PID 0xFF as an ordinary PID. Duplicate tags inside one set expose a design that picks the highest matching way. Lookups that fail with 0xA or 0xB expose a design that loads the refill slot on every failure. Hits expose a design that overwrites the cause word on success.

// File: rtl/tlb_pkg.sv
// Shared definitions for the TLB lookup unit: exception vectors and
// access codes written into the cause word.
package tlb_pkg;

    typedef enum logic [3:0] {
        VEC_NONE   = 4'h0,
        VEC_REFILL = 4'h8,
        VEC_PID    = 4'hA,
        VEC_WPROT  = 4'hB
    } tlb_vec_e;

    localparam logic [1:0] ACC_READ  = 2'b01;
    localparam logic [1:0] ACC_WRITE = 2'b10;

endpackage

// File: rtl/tlb_way_match.sv
// One-way tag comparator. Assumes the stored tag and the requested page
// number have the same width; a match is an exact equality of all bits.
module tlb_way_match #(
    parameter int VPN_W = 19
) (
    input  logic [VPN_W-1:0] way_tag,
    input  logic [VPN_W-1:0] req_vpn,
    output logic             match
);

    // Compare the stored tag to the page number being looked up.
    always_comb begin
        match = (way_tag == req_vpn);
    end

endmodule

// File: rtl/tlb_first_hit.sv
// Priority encoder over the per-way match lines. The lowest-numbered
// matching way wins; assumes WAYS is a power of two.
module tlb_first_hit #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  match,
    output logic             any_hit,
    output logic [WAY_W-1:0] hit_way
);

    // Walk from the top way down so the lowest match is left standing.
    always_comb begin
        any_hit = 1'b0;
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match[i]) begin
                any_hit = 1'b1;
                hit_way = WAY_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_fault_eval.sv
// Permission evaluation of the selected entry. Produces exactly one
// vector in priority order: refill (miss or invalid), PID mismatch,
// write protection. Assumes the entry fields belong to the hit way.
module tlb_fault_eval
    import tlb_pkg::*;
#(
    parameter int PID_W = 8
) (
    input  logic             any_hit,
    input  logic             ent_global,
    input  logic             ent_valid,
    input  logic             ent_writable,
    input  logic [PID_W-1:0] ent_pid,
    input  logic [PID_W-1:0] cur_pid,
    input  logic             is_write,
    input  logic             chk_valid,
    input  logic             chk_write,
    output tlb_vec_e         vec,
    output logic             need_refill,
    output logic             ok
);

    localparam logic [PID_W-1:0] PID_ANY = '1;

    logic bad_valid;
    logic bad_pid;
    logic bad_write;

    // Raw fault conditions, each independent of the others.
    always_comb begin
        bad_valid = chk_valid && !ent_valid;
        bad_pid   = !ent_global && (ent_pid != PID_ANY) && (ent_pid != cur_pid);
        bad_write = is_write && chk_write && !ent_writable;
    end

    // Resolve the conditions into one vector by priority.
    always_comb begin
        vec         = VEC_NONE;
        need_refill = 1'b0;
        ok          = 1'b0;
        if (!any_hit || bad_valid) begin
            vec         = VEC_REFILL;
            need_refill = 1'b1;
        end else if (bad_pid) begin
            vec = VEC_PID;
        end else if (bad_write) begin
            vec = VEC_WPROT;
        end else begin
            ok = 1'b1;
        end
    end

endmodule

// File: rtl/tlb_lookup.sv
// Set-associative TLB lookup. A request drives the set index to an
// external storage with a combinational read port, compares all ways,
// evaluates permissions and registers the result one cycle later. On a
// failure the cause word is captured; on a miss or invalid entry the
// refill select word is loaded with the set index and way zero.
// Assumes PAGE_BITS >= PID_W + 3 so the cause layout fits ADDR_W bits.
module tlb_lookup
    import tlb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13,
    parameter int SETS      = 16,
    parameter int WAYS      = 4,
    parameter int PID_W     = 8,
    localparam int IDX_W    = $clog2(SETS),
    localparam int WAY_W    = $clog2(WAYS),
    localparam int VPN_W    = ADDR_W - PAGE_BITS,
    localparam int SEL_W    = IDX_W + WAY_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  req_write,
    input  logic [PID_W-1:0]      cur_pid,
    input  logic                  cfg_chk_valid,
    input  logic                  cfg_chk_write,
    output logic [IDX_W-1:0]      rd_index,
    input  logic [WAYS*VPN_W-1:0] rd_tag,
    input  logic [WAYS*PID_W-1:0] rd_pid,
    input  logic [WAYS*VPN_W-1:0] rd_pfn,
    input  logic [WAYS-1:0]       rd_global,
    input  logic [WAYS-1:0]       rd_valid,
    input  logic [WAYS-1:0]       rd_writable,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic [3:0]            rsp_vec,
    output logic [ADDR_W-1:0]     rsp_paddr,
    output logic [ADDR_W-1:0]     cause_reg,
    output logic [SEL_W-1:0]      sel_reg
);

    localparam int CAUSE_PAD = PAGE_BITS - PID_W - 2;

    logic [VPN_W-1:0]     req_vpn;
    logic [WAYS-1:0]      way_hit;
    logic                 any_hit;
    logic [WAY_W-1:0]     hit_way;
    logic [VPN_W-1:0]     sel_pfn;
    logic [PID_W-1:0]     sel_pid;
    logic                 sel_global;
    logic                 sel_valid;
    logic                 sel_writable;
    tlb_vec_e             vec;
    logic                 need_refill;
    logic                 ok;
    logic [ADDR_W-1:0]    cause_next;
    logic [SEL_W-1:0]     sel_next;

    // Split the address into page number and set index.
    always_comb begin
        req_vpn  = req_addr[ADDR_W-1:PAGE_BITS];
        rd_index = req_addr[PAGE_BITS +: IDX_W];
    end

    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb_way_match #(
            .VPN_W (VPN_W)
        ) u_match (
            .way_tag (rd_tag[w*VPN_W +: VPN_W]),
            .req_vpn (req_vpn),
            .match   (way_hit[w])
        );
    end

    tlb_first_hit #(
        .WAYS  (WAYS),
        .WAY_W (WAY_W)
    ) u_first (
        .match   (way_hit),
        .any_hit (any_hit),
        .hit_way (hit_way)
    );

    // Route the fields of the winning way.
    always_comb begin
        sel_pfn      = rd_pfn[hit_way*VPN_W +: VPN_W];
        sel_pid      = rd_pid[hit_way*PID_W +: PID_W];
        sel_global   = rd_global[hit_way];
        sel_valid    = rd_valid[hit_way];
        sel_writable = rd_writable[hit_way];
    end

    tlb_fault_eval #(
        .PID_W (PID_W)
    ) u_eval (
        .any_hit      (any_hit),
        .ent_global   (sel_global),
        .ent_valid    (sel_valid),
        .ent_writable (sel_writable),
        .ent_pid      (sel_pid),
        .cur_pid      (cur_pid),
        .is_write     (req_write),
        .chk_valid    (cfg_chk_valid),
        .chk_write    (cfg_chk_write),
        .vec          (vec),
        .need_refill  (need_refill),
        .ok           (ok)
    );

    // Form the cause word and the refill slot for this request.
    always_comb begin
        cause_next = {req_vpn, {CAUSE_PAD{1'b0}},
                      (req_write ? ACC_WRITE : ACC_READ), cur_pid};
        sel_next   = {{WAY_W{1'b0}}, rd_index};
    end

    // Response strobe: high the cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= req_valid;
    end

    // Response fields, loaded on each request and held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit   <= 1'b0;
            rsp_vec   <= 4'h0;
            rsp_paddr <= '0;
        end else if (req_valid) begin
            rsp_hit   <= ok;
            rsp_vec   <= vec;
            rsp_paddr <= ok ? {sel_pfn, req_addr[PAGE_BITS-1:0]} : '0;
        end
    end

    // Cause word, captured on every failed lookup.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cause_reg <= '0;
        else if (req_valid && !ok)  cause_reg <= cause_next;
    end

    // Refill slot, loaded on a miss or an invalid entry only.
    always_ff @(posedge clk) begin
        if (!rst_n)                         sel_reg <= '0;
        else if (req_valid && need_refill)  sel_reg <= sel_next;
    end

endmodule

// File: rtl/tlb_lookup_chk.sv
// Temporal checks on the lookup unit's ports, bound to every instance.
module tlb_lookup_chk #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13,
    parameter int IDX_W     = 4,
    parameter int SEL_W     = 6,
    parameter int PID_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [PID_W-1:0]  cur_pid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [3:0]        rsp_vec,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [ADDR_W-1:0] cause_reg,
    input logic [SEL_W-1:0]  sel_reg
);

    p_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_hit_vec_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_vec == 4'h0));

    p_one_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |->
            (rsp_vec == 4'h8 || rsp_vec == 4'hA || rsp_vec == 4'hB));

    p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |->
            (rsp_paddr[PAGE_BITS-1:0] == $past(req_addr[PAGE_BITS-1:0])));

    p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_vec != 4'h8) |-> $stable(sel_reg));

    p_sel_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_vec == 4'h8) |->
            (sel_reg == SEL_W'($past(req_addr[PAGE_BITS +: IDX_W]))));

    p_cause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> $stable(cause_reg));

    p_cause_pid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (cause_reg[PID_W-1:0] == $past(cur_pid)));

endmodule

bind tlb_lookup tlb_lookup_chk #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .IDX_W     (IDX_W),
    .SEL_W     (SEL_W),
    .PID_W     (PID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .cur_pid   (cur_pid),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_vec   (rsp_vec),
    .rsp_paddr (rsp_paddr),
    .cause_reg (cause_reg),
    .sel_reg   (sel_reg)
);

// File: tb/tlb_lookup_tb.sv
`timescale 1ns/1ps
module tlb_lookup_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [7:0]  cur_pid = '0;
    logic        cfg_chk_valid = 1'b0;
    logic        cfg_chk_write = 1'b0;
    logic [3:0]  rd_index;
    logic [75:0] rd_tag;
    logic [31:0] rd_pid;
    logic [75:0] rd_pfn;
    logic [3:0]  rd_global;
    logic [3:0]  rd_valid;
    logic [3:0]  rd_writable;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [3:0]  rsp_vec;
    logic [31:0] rsp_paddr;
    logic [31:0] cause_reg;
    logic [5:0]  sel_reg;

    int n_checks = 0;
    int n_errors = 0;

    logic [18:0] m_tag [16][4];
    logic [18:0] m_pfn [16][4];
    logic [7:0]  m_pid [16][4];
    logic        m_g   [16][4];
    logic        m_v   [16][4];
    logic        m_w   [16][4];

    logic [31:0] exp_cause = '0;
    logic [5:0]  exp_sel = '0;

    always #4 clk = ~clk;

    tlb_lookup u_dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
        .req_addr (req_addr), .req_write (req_write), .cur_pid (cur_pid),
        .cfg_chk_valid (cfg_chk_valid), .cfg_chk_write (cfg_chk_write),
        .rd_index (rd_index), .rd_tag (rd_tag), .rd_pid (rd_pid),
        .rd_pfn (rd_pfn), .rd_global (rd_global), .rd_valid (rd_valid),
        .rd_writable (rd_writable), .rsp_valid (rsp_valid),
        .rsp_hit (rsp_hit), .rsp_vec (rsp_vec), .rsp_paddr (rsp_paddr),
        .cause_reg (cause_reg), .sel_reg (sel_reg)
    );

    // Entry storage model with a combinational read port.
    always_comb begin
        for (int w = 0; w < 4; w++) begin
            rd_tag[w*19 +: 19]  = m_tag[rd_index][w];
            rd_pfn[w*19 +: 19]  = m_pfn[rd_index][w];
            rd_pid[w*8 +: 8]    = m_pid[rd_index][w];
            rd_global[w]        = m_g[rd_index][w];
            rd_valid[w]         = m_v[rd_index][w];
            rd_writable[w]      = m_w[rd_index][w];
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Issue one lookup, predict its result from the requirements, compare.
    task automatic lookup(input logic [31:0] a, input logic wr,
                          input logic [7:0] pid, input logic cv, input logic cw,
                          input string rtag);
        logic [18:0] vpn;
        logic [3:0]  idx;
        int          way;
        logic [3:0]  ev;
        logic [31:0] ep;
        vpn = a[31:13];
        idx = a[16:13];
        way = -1;
        for (int w = 3; w >= 0; w--)
            if (m_tag[idx][w] == vpn) way = w;
        ep = '0;
        if (way < 0 || (cv && !m_v[idx][way])) ev = 4'h8;
        else if (!m_g[idx][way] && m_pid[idx][way] != 8'hFF &&
                 m_pid[idx][way] != pid) ev = 4'hA;
        else if (wr && cw && !m_w[idx][way]) ev = 4'hB;
        else begin
            ev = 4'h0;
            ep = {m_pfn[idx][way], a[12:0]};
        end
        if (ev != 4'h0) exp_cause = {vpn, 3'b000, (wr ? 2'b10 : 2'b01), pid};
        if (ev == 4'h8) exp_sel = {2'b00, idx};
        @(negedge clk);
        req_addr = a; req_write = wr; cur_pid = pid;
        cfg_chk_valid = cv; cfg_chk_write = cw; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3", "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(rtag, "rsp_vec", 32'(rsp_vec), 32'(ev));
        chk("R11", "rsp_hit", 32'(rsp_hit), 32'(ev == 4'h0));
        chk("R1", "rsp_paddr", rsp_paddr, ep);
        chk("R9", "cause_reg", cause_reg, exp_cause);
        chk("R4", "sel_reg", 32'(sel_reg), 32'(exp_sel));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++) begin
                m_tag[s][w] = {15'(16'h100 + w*16'h111 + s), 4'(s)};
                m_pfn[s][w] = 19'(19'h40000 + s*64 + w*5);
                m_pid[s][w] = 8'h00;
                m_g[s][w] = 1'b1; m_v[s][w] = 1'b1; m_w[s][w] = 1'b1;
            end
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "rsp_valid", 32'(rsp_valid), 0);
        chk("R10", "rsp_hit", 32'(rsp_hit), 0);
        chk("R10", "rsp_vec", 32'(rsp_vec), 0);
        chk("R10", "rsp_paddr", rsp_paddr, 0);
        chk("R10", "cause_reg", cause_reg, 0);
        chk("R10", "sel_reg", 32'(sel_reg), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R11: hit in every way of every set
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++)
                lookup({m_tag[s][w], 13'(s*311 + w*97)}, 1'((s + w) % 2),
                       8'h21, 1'b1, 1'b1, "R11");

        // R3: strobe drops after one cycle, results held
        @(negedge clk);
        chk("R3", "rsp_valid low", 32'(rsp_valid), 0);
        chk("R3", "rsp_hit held", 32'(rsp_hit), 1);

        // R4: miss in every set
        for (int s = 0; s < 16; s++)
            lookup({15'h7FFF, 4'(s), 13'(s*5)}, 1'(s % 2), 8'(s*9), 1'b1, 1'b0, "R4");

        // R2: duplicate tags, lowest way wins
        m_tag[9][3] = m_tag[9][1];
        lookup({m_tag[9][1], 13'h0ABC}, 1'b0, 8'h01, 1'b1, 1'b1, "R2");
        chk("R2", "way1 frame", 32'(rsp_paddr[31:13]), 32'(m_pfn[9][1]));
        m_tag[9][0] = m_tag[9][1];
        lookup({m_tag[9][1], 13'h1FFF}, 1'b1, 8'h01, 1'b1, 1'b1, "R2");
        chk("R2", "way0 frame", 32'(rsp_paddr[31:13]), 32'(m_pfn[9][0]));

        // R5..R8: every flag, PID kind, direction and enable combination
        for (int g = 0; g < 2; g++)
            for (int v = 0; v < 2; v++)
                for (int wf = 0; wf < 2; wf++)
                    for (int pk = 0; pk < 3; pk++)
                        for (int wr = 0; wr < 2; wr++)
                            for (int cv = 0; cv < 2; cv++)
                                for (int cw = 0; cw < 2; cw++) begin
                                    string t;
                                    m_g[5][2] = 1'(g);
                                    m_v[5][2] = 1'(v);
                                    m_w[5][2] = 1'(wf);
                                    m_pid[5][2] = (pk == 0) ? 8'h3C :
                                                  (pk == 1) ? 8'h55 : 8'hFF;
                                    if (cv == 1 && v == 0) t = "R5";
                                    else if (g == 0 && pk == 1) t = "R6";
                                    else if (wr == 1 && cw == 1 && wf == 0) t = "R7";
                                    else t = "R8";
                                    lookup({m_tag[5][2], 13'(pk*1000 + wr*7)},
                                           1'(wr), 8'h3C, 1'(cv), 1'(cw), t);
                                end

        // R8: all three faults at once report only the refill vector
        m_g[5][2] = 1'b0; m_v[5][2] = 1'b0; m_w[5][2] = 1'b0; m_pid[5][2] = 8'h55;
        lookup({m_tag[5][2], 13'h0123}, 1'b1, 8'h3C, 1'b1, 1'b1, "R8");
        chk("R8", "single refill vector", 32'(rsp_vec), 32'h8);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule